// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Sticky Status Flags

This block sends and receives asynchronous serial characters of 8 data bits, least significant bit first. Each direction has a single holding register between the CPU side and the shift logic. The CPU writes a byte with a one-cycle write strobe. When the transmitter is idle, the byte moves into the shift logic. The receiver stores each complete character in a read buffer, and a one-cycle read strobe empties that buffer.

Bit timing comes from a programmable divider. The divider produces one tick every `baud_div_i + 1` clock cycles, and each serial bit lasts 16 ticks. Three static inputs set the frame format:

- parity on or off;
- odd or even parity;
- one or two stop bits.

A 7-bit status word reports the following:

- busy;
- transmit holding empty;
- receive buffer empty;
- four sticky error flags: transmit overflow, line break, framing and parity.

Software clears an error flag by writing 0 to its bit in the status word.

Top module: `serial_xcvr`

## Requirements
- R1: Status bit layout: bit 0 busy, bit 1 TX holding empty, bit 2 RX buffer empty, bit 3 TX overflow, bit 4 break, bit 5 framing error, bit 6 parity error. After reset the status word is 7'b0000110 and `tx_o` is 1.
- R2: A transmitted frame is the following sequence. Each bit lasts 16*(baud_div_i+1) clock cycles, and the line idles at 1.
  - a start bit of 0;
  - the 8 data bits, LSB first;
  - the parity bit, if parity is enabled;
  - one stop bit of 1, or two when `stop2_i` is set.
- R3: The parity bit makes the count of ones over data plus parity even when `par_odd_i`=0, and odd when `par_odd_i`=1.
- R4: A data write clears the TX-empty flag. The flag sets again when the held byte moves into the shift logic.
- R5: A data write while the holding register is full sets the overflow flag, and that byte is never transmitted.
- R6: The busy flag is 1 while a character is being sent or received, and returns to 0 once both directions are idle.
- R7: A complete received character appears on `rdata_o` and clears the RX-empty flag. A read strobe sets the RX-empty flag.
- R8: When parity is enabled, a received parity bit that disagrees with the data sets the parity-error flag. The character is still stored.
- R9: A 0 sampled at the first stop-bit position sets the framing-error flag. When the line then returns to 1 within one character time, the character is stored.
- R10: A line held at 0 for longer than one character time (start, data, parity if enabled, stop bits) sets the break flag and stores no character. The receiver waits for the line to return to 1 before it accepts the next start bit.
- R11: Writing 0 to any of bits 3 to 6 clears that flag, and writing 1 leaves it unchanged. A set condition in the same cycle as a clearing write keeps the flag set. Writes have no effect on bits 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_div_i | input | DIV_W | Tick divisor: one tick per baud_div_i+1 cycles |
| par_en_i | input | 1 | Parity bit present in frames |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| stop2_i | input | 1 | 1 selects two stop bits on transmit |
| wr_data_i | input | 1 | Data write strobe |
| wdata_i | input | DW | Byte to transmit |
| rd_data_i | input | 1 | Data read strobe |
| rdata_o | output | DW | Last received byte |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 7 | Status write value; a 0 clears a sticky flag |
| stat_o | output | 7 | Status word |
| tx_o | output | 1 | Serial output line |
| rx_i | input | 1 | Serial input line |

## Verification
The bench instantiates the block with DIV_W=4, OS=16 and DW=8. Most scenarios use divisor 0, which makes a bit 16 cycles long. At that length a break of fourteen bit times and many complete frames fit in a few thousand cycles. One transmit scenario uses divisor 2 with two stop bits. It shows that the divider stretches every bit, including the second stop bit, to 48 cycles.

// File: rtl/sx_pkg.sv
package sx_pkg;
  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic stop2;
  } frame_cfg_t;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_LOW, RX_BRK} rx_state_e;

  localparam int unsigned ST_W      = 7;
  localparam int unsigned ST_BUSY   = 0;
  localparam int unsigned ST_TXE    = 1;
  localparam int unsigned ST_RXE    = 2;
  localparam int unsigned ST_OVF    = 3;
  localparam int unsigned ST_BRK    = 4;
  localparam int unsigned ST_FRM    = 5;
  localparam int unsigned ST_PAR    = 6;
  localparam int unsigned STICKY_LO = 3;
  localparam int unsigned N_STICKY  = ST_W - STICKY_LO;
endpackage

// File: rtl/sx_baud_gen.sv
module sx_baud_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sx_tx.sv
module sx_tx
  import sx_pkg::*;
#(
  parameter int unsigned OS = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  frame_cfg_t    cfg_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          take_o,
  output logic          tx_o,
  output logic          busy_o
);
  localparam int unsigned SUB_W = $clog2(OS);
  localparam int unsigned IDX_W = $clog2(DW);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DW - 1);

  tx_state_e        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    sh_q;
  logic             par_q;
  logic             stop_q;
  frame_cfg_t       cfg_q;
  logic             bit_end;

  assign bit_end = tick_i && (sub_q == SUB_LAST);
  assign take_o  = (state_q == TX_IDLE) && load_i;
  assign busy_o  = (state_q != TX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      stop_q  <= 1'b0;
      cfg_q   <= '0;
    end else if (state_q == TX_IDLE) begin
      if (load_i) begin
        sh_q    <= data_i;
        par_q   <= ^data_i ^ cfg_i.par_odd;
        cfg_q   <= cfg_i;
        sub_q   <= '0;
        idx_q   <= '0;
        state_q <= TX_START;
      end
    end else begin
      if (tick_i) sub_q <= bit_end ? '0 : sub_q + 1'b1;
      if (bit_end) begin
        unique case (state_q)
          TX_START: begin
            state_q <= TX_DATA;
            idx_q   <= '0;
          end
          TX_DATA: begin
            sh_q <= sh_q >> 1;
            if (idx_q == IDX_LAST) begin
              state_q <= cfg_q.par_en ? TX_PAR : TX_STOP;
              stop_q  <= 1'b0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          TX_PAR: begin
            state_q <= TX_STOP;
            stop_q  <= 1'b0;
          end
          TX_STOP: begin
            if (stop_q == cfg_q.stop2) state_q <= TX_IDLE;
            else stop_q <= 1'b1;
          end
          default: state_q <= TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      TX_START: tx_o = 1'b0;
      TX_DATA:  tx_o = sh_q[0];
      TX_PAR:   tx_o = par_q;
      default:  tx_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sx_rx.sv
module sx_rx
  import sx_pkg::*;
#(
  parameter int unsigned OS = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  frame_cfg_t    cfg_i,
  input  logic          rx_s_i,
  output logic          store_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o,
  output logic          busy_o
);
  localparam int unsigned SUB_W = $clog2(OS);
  localparam int unsigned IDX_W = $clog2(DW);
  localparam int unsigned LCW   = $clog2(OS * (DW + 4) + 2);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OS / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DW - 1);

  rx_state_e        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    sh_q;
  logic             par_q;
  logic [LCW-1:0]   low_q;
  logic [LCW-1:0]   char_ticks;
  logic             bit_end;
  logic             mid_end;
  logic             brk_det;
  logic             par_bad;

  // one character time in ticks, first stop bit only counted once per stop
  assign char_ticks = LCW'(OS * (DW + 2 + 32'(cfg_i.par_en) + 32'(cfg_i.stop2)));
  assign bit_end = tick_i && (sub_q == SUB_LAST);
  assign mid_end = tick_i && (sub_q == SUB_MID);
  assign brk_det = tick_i && !rx_s_i && (low_q == char_ticks) && (state_q != RX_BRK);
  assign par_bad = cfg_i.par_en && (par_q != (^sh_q ^ cfg_i.par_odd));
  assign busy_o  = (state_q != RX_IDLE);
  assign data_o  = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_q <= '0;
    else if (rx_s_i) low_q <= '0;
    else if (tick_i && (low_q <= char_ticks)) low_q <= low_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      store_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      store_o <= 1'b0;
      brk_o   <= 1'b0;
      if (brk_det) begin
        state_q <= RX_BRK;
        brk_o   <= 1'b1;
      end else begin
        unique case (state_q)
          RX_IDLE: if (!rx_s_i) begin
            state_q <= RX_START;
            sub_q   <= '0;
          end
          RX_START: begin
            if (mid_end) begin
              sub_q   <= '0;
              idx_q   <= '0;
              state_q <= rx_s_i ? RX_IDLE : RX_DATA;
            end else if (tick_i) sub_q <= sub_q + 1'b1;
          end
          RX_DATA: begin
            if (bit_end) begin
              sub_q <= '0;
              sh_q  <= {rx_s_i, sh_q[DW-1:1]};
              if (idx_q == IDX_LAST) state_q <= cfg_i.par_en ? RX_PAR : RX_STOP;
              else idx_q <= idx_q + 1'b1;
            end else if (tick_i) sub_q <= sub_q + 1'b1;
          end
          RX_PAR: begin
            if (bit_end) begin
              sub_q   <= '0;
              par_q   <= rx_s_i;
              state_q <= RX_STOP;
            end else if (tick_i) sub_q <= sub_q + 1'b1;
          end
          RX_STOP: begin
            if (bit_end) begin
              sub_q <= '0;
              if (rx_s_i) begin
                store_o <= 1'b1;
                ferr_o  <= 1'b0;
                perr_o  <= par_bad;
                state_q <= RX_IDLE;
              end else begin
                state_q <= RX_LOW;
              end
            end else if (tick_i) sub_q <= sub_q + 1'b1;
          end
          RX_LOW: if (rx_s_i) begin
            // bad stop bit, line recovered before break time
            store_o <= 1'b1;
            ferr_o  <= 1'b1;
            perr_o  <= par_bad;
            state_q <= RX_IDLE;
          end
          RX_BRK: if (rx_s_i) state_q <= RX_IDLE;
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sx_flags.sv
module sx_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o[i] <= 1'b0;
      else flags_o[i] <= set_i[i] | (flags_o[i] & ~(wr_i & ~wdata_i[i]));
    end
  end
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import sx_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned OS    = 16,
  parameter int unsigned DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             stop2_i,
  input  logic             wr_data_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_data_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             stat_wr_i,
  input  logic [ST_W-1:0]  stat_wdata_i,
  output logic [ST_W-1:0]  stat_o,
  output logic             tx_o,
  input  logic             rx_i
);
  frame_cfg_t cfg;
  logic       tick;
  logic [1:0] rx_sync_q;
  logic       rx_s;

  logic [DW-1:0] hold_q;
  logic          hold_v_q;
  logic          take;
  logic          tx_busy;

  logic          rx_store;
  logic [DW-1:0] rx_data;
  logic          rx_perr;
  logic          rx_ferr;
  logic          rx_brk;
  logic          rx_busy;
  logic          rx_full_q;

  logic [N_STICKY-1:0] sticky_set;
  logic [N_STICKY-1:0] sticky;
  logic                unused_wbits;

  assign cfg = '{par_en: par_en_i, par_odd: par_odd_i, stop2: stop2_i};
  assign rx_s = rx_sync_q[1];
  assign unused_wbits = ^stat_wdata_i[STICKY_LO-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_sync_q <= 2'b11;
    else rx_sync_q <= {rx_sync_q[0], rx_i};
  end

  sx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (baud_div_i),
    .tick_o(tick)
  );

  // TX holding register: writes land only when empty, shifter drains it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else if (take) begin
      hold_v_q <= 1'b0;
    end else if (wr_data_i && !hold_v_q) begin
      hold_q   <= wdata_i;
      hold_v_q <= 1'b1;
    end
  end

  sx_tx #(.OS(OS), .DW(DW)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .cfg_i (cfg),
    .load_i(hold_v_q),
    .data_i(hold_q),
    .take_o(take),
    .tx_o  (tx_o),
    .busy_o(tx_busy)
  );

  sx_rx #(.OS(OS), .DW(DW)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .cfg_i  (cfg),
    .rx_s_i (rx_s),
    .store_o(rx_store),
    .data_o (rx_data),
    .perr_o (rx_perr),
    .ferr_o (rx_ferr),
    .brk_o  (rx_brk),
    .busy_o (rx_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      rx_full_q <= 1'b0;
    end else if (rx_store) begin
      rdata_o   <= rx_data;
      rx_full_q <= 1'b1;
    end else if (rd_data_i) begin
      rx_full_q <= 1'b0;
    end
  end

  assign sticky_set[ST_OVF-STICKY_LO] = wr_data_i && hold_v_q;
  assign sticky_set[ST_BRK-STICKY_LO] = rx_brk;
  assign sticky_set[ST_FRM-STICKY_LO] = rx_store && rx_ferr;
  assign sticky_set[ST_PAR-STICKY_LO] = rx_store && rx_perr;

  sx_flags #(.N(N_STICKY)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sticky_set),
    .wr_i   (stat_wr_i),
    .wdata_i(stat_wdata_i[ST_W-1:STICKY_LO]),
    .flags_o(sticky)
  );

  assign stat_o[ST_BUSY] = tx_busy | rx_busy;
  assign stat_o[ST_TXE]  = ~hold_v_q;
  assign stat_o[ST_RXE]  = ~rx_full_q;
  assign stat_o[ST_W-1:STICKY_LO] = sticky;
endmodule

// File: rtl/sx_checker.sv
module sx_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_data_i,
  input logic       stat_wr_i,
  input logic [6:0] stat_wdata_i,
  input logic [6:0] stat_o,
  input logic       tx_o
);
  // R4: a write into an empty holding register leaves it full next cycle
  a_r4_write_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && stat_o[1]) |=> !stat_o[1]);

  // R5: a write into a full holding register raises overflow
  a_r5_full_write_overflows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && !stat_o[1]) |=> stat_o[3]);

  // R11: overflow stays set unless cleared by a zero write
  a_r11_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[3] && !(stat_wr_i && !stat_wdata_i[3])) |=> stat_o[3]);

  // R11: framing flag stays set unless cleared by a zero write
  a_r11_frm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[5] && !(stat_wr_i && !stat_wdata_i[5])) |=> stat_o[5]);

  // R2: line idles high whenever nothing is in progress
  a_r2_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_o[0] |-> tx_o);
endmodule

bind serial_xcvr sx_checker u_sx_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_data_i   (wr_data_i),
  .stat_wr_i   (stat_wr_i),
  .stat_wdata_i(stat_wdata_i),
  .stat_o      (stat_o),
  .tx_o        (tx_o)
);

// File: tb/sim_serial_xcvr.sv
`timescale 1ns/1ps
module sim_serial_xcvr;
  localparam int unsigned DIV_W = 4;
  localparam int unsigned OS    = 16;
  localparam int unsigned DW    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] baud_div = '0;
  logic             par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic             wr_data = 1'b0;
  logic [DW-1:0]    wdata = '0;
  logic             rd_data = 1'b0;
  logic [DW-1:0]    rdata;
  logic             stat_wr = 1'b0;
  logic [6:0]       stat_wdata = '0;
  logic [6:0]       stat;
  logic             tx;
  logic             rx = 1'b1;

  int nvec = 0;
  int nfail = 0;
  int bit_cyc = OS;

  always #4 clk = ~clk;

  serial_xcvr #(.DIV_W(DIV_W), .OS(OS), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .baud_div_i(baud_div),
    .par_en_i(par_en), .par_odd_i(par_odd), .stop2_i(stop2),
    .wr_data_i(wr_data), .wdata_i(wdata), .rd_data_i(rd_data), .rdata_o(rdata),
    .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata), .stat_o(stat),
    .tx_o(tx), .rx_i(rx)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_div(input int d);
    baud_div = DIV_W'(d);
    bit_cyc = OS * (d + 1);
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr_data = 1'b1; wdata = d;
    @(negedge clk); wr_data = 1'b0;
  endtask

  task automatic wr_stat(input logic [6:0] v);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  task automatic rd_byte();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // capture one frame from tx, sampling at mid-bit
  task automatic cap_tx(input bit pen, input bit two_stop, output logic [7:0] d,
                        output logic p, output logic s1, output logic s2, output logic busy_mid);
    while (tx !== 1'b0) @(negedge clk);
    repeat (bit_cyc / 2) @(negedge clk);
    chk("R2", "start bit", tx, 1'b0);
    p = 1'b0; s2 = 1'b1; busy_mid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (bit_cyc) @(negedge clk);
      d[i] = tx;
      if (i == 4) busy_mid = stat[0];
    end
    if (pen) begin repeat (bit_cyc) @(negedge clk); p = tx; end
    repeat (bit_cyc) @(negedge clk); s1 = tx;
    if (two_stop) begin
      repeat (bit_cyc) @(negedge clk); s2 = tx;
      chk("R6", "busy during second stop", stat[0], 1'b1);
    end
    repeat (bit_cyc / 2) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit pen, input bit podd,
                         input bit flip_par, input bit stop_v);
    @(negedge clk); rx = 1'b0;
    repeat (bit_cyc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (bit_cyc) @(negedge clk);
    end
    if (pen) begin
      rx = (^d) ^ podd ^ flip_par;
      repeat (bit_cyc) @(negedge clk);
    end
    rx = stop_v;
    repeat (bit_cyc) @(negedge clk);
    rx = 1'b1;
    repeat (bit_cyc) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "status after reset", stat, 7'b0000110);
    chk("R1", "tx line after reset", tx, 1'b1);
  endtask

  task automatic t_tx_basic();
    logic [7:0] d; logic p, s1, s2, bm;
    set_div(0); par_en = 0; stop2 = 0;
    fork
      cap_tx(1'b0, 1'b0, d, p, s1, s2, bm);
      wr_byte(8'hA5);
    join
    chk("R2", "tx data A5", d, 8'hA5);
    chk("R2", "tx stop", s1, 1'b1);
    chk("R6", "busy mid frame", bm, 1'b1);
    idle(4);
    chk("R6", "busy cleared after frame", stat[0], 1'b0);
    chk("R4", "tx empty after frame", stat[1], 1'b1);
  endtask

  task automatic t_tx_parity(input bit odd);
    logic [7:0] d; logic p, s1, s2, bm;
    set_div(0); par_en = 1; par_odd = odd; stop2 = 0;
    fork
      cap_tx(1'b1, 1'b0, d, p, s1, s2, bm);
      wr_byte(8'h37);
    join
    chk("R3", "tx data with parity", d, 8'h37);
    chk("R3", odd ? "odd parity bit" : "even parity bit", p, (^8'h37) ^ odd);
    chk("R2", "stop after parity", s1, 1'b1);
    idle(4);
    par_en = 0; par_odd = 0;
  endtask

  task automatic t_tx_two_stop_div();
    logic [7:0] d; logic p, s1, s2, bm;
    set_div(2); par_en = 0; stop2 = 1;
    fork
      cap_tx(1'b0, 1'b1, d, p, s1, s2, bm);
      wr_byte(8'h5A);
    join
    chk("R2", "tx data div 2", d, 8'h5A);
    chk("R2", "first stop", s1, 1'b1);
    chk("R2", "second stop", s2, 1'b1);
    idle(4);
    stop2 = 0; set_div(0);
  endtask

  task automatic t_empty_ovf();
    logic [7:0] d; logic p, s1, s2, bm;
    set_div(0);
    fork
      cap_tx(1'b0, 1'b0, d, p, s1, s2, bm);
      begin
        @(negedge clk); wr_data = 1'b1; wdata = 8'h11;
        @(negedge clk); wr_data = 1'b0;
        chk("R4", "empty cleared by write", stat[1], 1'b0);
        @(negedge clk);
        chk("R4", "empty set after move to shifter", stat[1], 1'b1);
        wr_data = 1'b1; wdata = 8'h22;
        @(negedge clk);
        chk("R4", "holding full while busy", stat[1], 1'b0);
        wdata = 8'h33;
        stat_wr = 1'b1; stat_wdata = 7'b0;   // clear in same cycle as overflow
        @(negedge clk); wr_data = 1'b0; stat_wr = 1'b0;
        chk("R5", "overflow on full write", stat[3], 1'b1);
        chk("R11", "set wins over clear", stat[3], 1'b1);
      end
    join
    chk("R5", "first frame", d, 8'h11);
    cap_tx(1'b0, 1'b0, d, p, s1, s2, bm);
    chk("R5", "held byte sent, not overflow byte", d, 8'h22);
    idle(3 * bit_cyc);
    chk("R5", "overflow byte discarded, line idle", tx, 1'b1);
    chk("R5", "not busy after discard", stat[0], 1'b0);
  endtask

  task automatic t_clear();
    wr_stat(7'h7F);
    chk("R11", "write 1 keeps overflow", stat[3], 1'b1);
    wr_stat(7'h77);
    chk("R11", "write 0 clears overflow", stat[3], 1'b0);
    wr_stat(7'h00);
    chk("R11", "low bits unaffected by write", stat, 7'b0000110);
  endtask

  task automatic t_rx_good();
    par_en = 0;
    send_rx(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7", "rx data", rdata, 8'h3C);
    chk("R7", "rx empty cleared", stat[2], 1'b0);
    chk("R9", "no framing error", stat[5], 1'b0);
    rd_byte();
    chk("R7", "rx empty set by read", stat[2], 1'b1);
  endtask

  task automatic t_rx_parity();
    par_en = 1; par_odd = 1;
    send_rx(8'hC3, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R8", "good odd parity data", rdata, 8'hC3);
    chk("R8", "no parity error", stat[6], 1'b0);
    send_rx(8'h81, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R8", "bad parity data stored", rdata, 8'h81);
    chk("R8", "parity error set", stat[6], 1'b1);
    par_en = 0; par_odd = 0;
    rd_byte();
    wr_stat(7'h00);
    chk("R11", "parity error cleared", stat[6], 1'b0);
  endtask

  task automatic t_rx_frame();
    send_rx(8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "framing error set", stat[5], 1'b1);
    chk("R9", "character stored", rdata, 8'h55);
    chk("R9", "no break on short low", stat[4], 1'b0);
    rd_byte();
    wr_stat(7'h00);
  endtask

  task automatic t_break();
    @(negedge clk); rx = 1'b0;
    repeat (14 * bit_cyc) @(negedge clk);
    chk("R10", "break flag set", stat[4], 1'b1);
    chk("R10", "no character stored", stat[2], 1'b1);
    chk("R10", "no framing error for break", stat[5], 1'b0);
    rx = 1'b1;
    repeat (2 * bit_cyc) @(negedge clk);
    send_rx(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10", "receive after break", rdata, 8'h5A);
    chk("R10", "rx full after break recovery", stat[2], 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_tx_basic();
    t_tx_parity(1'b0);
    t_tx_parity(1'b1);
    t_tx_two_stop_div();
    t_empty_ovf();
    t_clear();
    t_rx_good();
    t_rx_parity();
    t_rx_frame();
    t_break();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule